// File: doc/BRIEF.md
# I2C Clock Phase Generator

This block produces the serial clock for an I2C master and tells the transfer engine when to move the data line. A 32-bit divider word carries two independent counts, one for the clock-low phase and one for the clock-high phase. Each count is measured in units of eight input clocks, so the duty cycle can be asymmetric. The generator drives the clock line low through an open-drain pull output. It reads the line back and holds off the high-phase count while a slave stretches the clock.

The engine steps the generator with a two-bit command. The generator consumes one command per bit slot. It pulses a change strobe halfway through every low phase, which is where the engine may alter SDA. It pulses a sample strobe halfway through the high phase of a data bit. For START, repeated START and STOP it inserts a hold phase with the clock released and marks the SDA transition point with a condition strobe. Dropping the run input abandons the transfer at once and releases the clock. The divider word is captured only when a low phase begins, or when a transfer leaves idle, so a new setting never shortens or stretches a phase that is already running.

Top module: `i2c_scl_phase_gen`

## Requirements
- R1: The low count is taken from div_cfg[15:0] and the high count from div_cfg[31:16].
- R2: Every clock-low phase (scl_pull = 1) lasts exactly (low count + 1) * 8 clock cycles.
- R3: Every clock-high phase lasts (high count + 1) * 8 cycles in which scl_in reads high. This covers data-bit high phases, repeated-START and STOP setup phases, and condition hold phases.
- R4: While busy with the clock released, a cycle with scl_in low is not counted. The high phase cannot end in that cycle, so the clock stays released and the generator stays busy.
- R5: The divider word is sampled on the clock edge that enters a low phase, and on the edge that leaves idle. A change in div_cfg during a phase does not alter that phase.
- R6: chg_stb fires exactly once per low phase, in its ((low count + 1) * 4)-th cycle, and never while the clock is released.
- R7: smp_stb fires exactly once per data-bit high phase, on its ((high count + 1) * 4)-th counted cycle, with scl_in high. It never fires in setup or hold phases.
- R8: Command codes are 0 = data bit, 1 = START, 2 = STOP, and 3 = data bit. START from idle enters a hold phase. START in a bus slot runs a setup high phase and then a hold phase. STOP runs a setup high phase, then a hold phase, then returns to idle. cond_stb marks the first cycle of every hold phase, with the clock released.
- R9: cmd_take pulses in the last cycle of each low phase, which is where the next command is consumed, and in an idle cycle where run is high and cmd is START. It pulses nowhere else.
- R10: While idle, commands other than START are ignored: the clock stays released and busy stays low.
- R11: When run is low at a clock edge, the generator is idle after that edge with the clock released.
- R12: After reset the generator is idle with the clock released and all strobes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Transfer enable from the engine; low aborts |
| cmd | input | 2 | Next bus action: 0 bit, 1 START, 2 STOP, 3 bit |
| div_cfg | input | 32 | Low count in [15:0], high count in [31:16] |
| scl_in | input | 1 | Clock line read back, already synchronised |
| scl_pull | output | 1 | 1 pulls the clock line low |
| chg_stb | output | 1 | SDA change point, middle of the low phase |
| smp_stb | output | 1 | SDA sample point, middle of a data high phase |
| cond_stb | output | 1 | SDA transition point of START, repeated START or STOP |
| cmd_take | output | 1 | Current cmd is consumed at the coming edge |
| busy | output | 1 | Generator is outside idle |

## Verification
The strobes, cmd_take and scl_pull are decoded from registered state and the counter, so they are valid in the same cycle that the counter reaches a compare value. A change of run or cmd becomes visible one edge later. The bench drives inputs 2 ns after a rising edge and samples at the falling edge. It measures each phase by counting sampled cycles from the first cycle in which scl_pull or cond_stb shows the new phase. It takes the expected counts from the divider word seen at the falling edge before that first cycle, which is the value present at the capturing edge. The abort check looks one full edge after run falls.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;

  typedef enum logic [1:0] {
    CMD_BIT   = 2'd0,
    CMD_START = 2'd1,
    CMD_STOP  = 2'd2,
    CMD_BIT_B = 2'd3
  } sg_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_RSU   = 3'd3,
    ST_PSU   = 3'd4,
    ST_SHOLD = 3'd5,
    ST_PHOLD = 3'd6
  } sg_state_e;

endpackage

// File: rtl/sclgen_div_shadow.sv
module sclgen_div_shadow #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [2*CNT_W-1:0] div_cfg,
  output logic [CNT_W-1:0]   lo_q,
  output logic [CNT_W-1:0]   hi_q
);

  localparam int NFLD = 2;

  logic [NFLD-1:0][CNT_W-1:0] fld;

  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    logic [CNT_W-1:0] q, d;

    always_comb begin
      d = load ? div_cfg[f*CNT_W +: CNT_W] : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign fld[f] = q;
  end

  assign lo_q = fld[0];
  assign hi_q = fld[1];

endmodule

// File: rtl/sclgen_phase_timer.sv
module sclgen_phase_timer #(
  parameter int CNT_W     = 16,
  parameter int PRE_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] units,
  output logic             mid,
  output logic             last
);

  localparam int TW = CNT_W + PRE_SHIFT + 1;

  logic [TW-1:0] cnt_q, cnt_d, span, half;

  always_comb begin
    span = (TW'(units) + TW'(1)) << PRE_SHIFT;
    half = (TW'(units) + TW'(1)) << (PRE_SHIFT - 1);
  end

  assign last = cnt_en && (cnt_q == span - TW'(1));
  assign mid  = cnt_en && (cnt_q == half - TW'(1));

  always_comb begin
    if (clr)         cnt_d = '0;
    else if (cnt_en) cnt_d = last ? '0 : cnt_q + TW'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < span); // R3

endmodule

// File: rtl/sclgen_seq.sv
module sclgen_seq
  import i2c_sclgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] cmd,
  input  logic       scl_in,
  input  logic       mid,
  input  logic       last,
  output logic       clr,
  output logic       cnt_en,
  output logic       div_load,
  output logic       scl_pull,
  output logic       chg_stb,
  output logic       smp_stb,
  output logic       cond_stb,
  output logic       cmd_take,
  output logic       busy
);

  sg_state_e st_q, st_d;
  logic      cond_q, cond_d;

  always_comb begin
    st_d     = st_q;
    cmd_take = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (run && (cmd == CMD_START)) begin
          st_d     = ST_SHOLD;
          cmd_take = 1'b1;
        end
      end
      ST_LOW: begin
        if (last) begin
          cmd_take = 1'b1;
          if (cmd == CMD_START)     st_d = ST_RSU;
          else if (cmd == CMD_STOP) st_d = ST_PSU;
          else                      st_d = ST_HIGH;
        end
      end
      ST_HIGH:  if (last) st_d = ST_LOW;
      ST_RSU:   if (last) st_d = ST_SHOLD;
      ST_PSU:   if (last) st_d = ST_PHOLD;
      ST_SHOLD: if (last) st_d = ST_LOW;
      ST_PHOLD: if (last) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
    if (!run) begin
      st_d     = ST_IDLE;
      cmd_take = 1'b0;
    end
  end

  always_comb begin
    clr      = (st_d != st_q);
    div_load = ((st_d == ST_LOW) && (st_q != ST_LOW)) ||
               ((st_q == ST_IDLE) && (st_d == ST_SHOLD));
    cond_d   = clr && ((st_d == ST_SHOLD) || (st_d == ST_PHOLD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cond_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cond_q <= cond_d;
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign scl_pull = (st_q == ST_LOW);
  assign cnt_en   = scl_pull || (busy && scl_in);
  assign chg_stb  = scl_pull && mid;
  assign smp_stb  = (st_q == ST_HIGH) && mid;
  assign cond_stb = cond_q;

  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!busy && !scl_pull)); // R11

  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && run && (cmd != CMD_START)) |=> !busy); // R10

  AST_COND_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    cond_stb |-> (busy && !scl_pull)); // R8

endmodule

// File: rtl/i2c_scl_phase_gen.sv
module i2c_scl_phase_gen
  import i2c_sclgen_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PRE_SHIFT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [1:0]         cmd,
  input  logic [2*CNT_W-1:0] div_cfg,
  input  logic               scl_in,
  output logic               scl_pull,
  output logic               chg_stb,
  output logic               smp_stb,
  output logic               cond_stb,
  output logic               cmd_take,
  output logic               busy
);

  logic [CNT_W-1:0] lo_q, hi_q, units;
  logic             div_load, clr, cnt_en, mid, last;

  sclgen_div_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (div_load),
    .div_cfg (div_cfg),
    .lo_q    (lo_q),
    .hi_q    (hi_q)
  );

  assign units = scl_pull ? lo_q : hi_q;

  sclgen_phase_timer #(.CNT_W(CNT_W), .PRE_SHIFT(PRE_SHIFT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .cnt_en (cnt_en),
    .units  (units),
    .mid    (mid),
    .last   (last)
  );

  sclgen_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .cmd      (cmd),
    .scl_in   (scl_in),
    .mid      (mid),
    .last     (last),
    .clr      (clr),
    .cnt_en   (cnt_en),
    .div_load (div_load),
    .scl_pull (scl_pull),
    .chg_stb  (chg_stb),
    .smp_stb  (smp_stb),
    .cond_stb (cond_stb),
    .cmd_take (cmd_take),
    .busy     (busy)
  );

  AST_LOW_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && $past(scl_pull)) |-> (lo_q == $past(lo_q))); // R5

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && busy && !scl_pull && !scl_in) |=> (busy && !scl_pull)); // R4

  AST_CHG_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    chg_stb |-> (scl_pull && !smp_stb)); // R6

  AST_SMP_WHEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (scl_in && !scl_pull)); // R7

endmodule

// File: tb/i2c_scl_phase_gen_bench.sv
module i2c_scl_phase_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n, run, stretch, scl_in;
  logic [1:0]  cmd;
  logic [31:0] div_cfg, div_force;
  logic        scl_pull, chg_stb, smp_stb, cond_stb, cmd_take, busy;
  bit          div_rand, stretch_en, done;
  int          checks, errors;

  always #4 clk = ~clk;

  i2c_scl_phase_gen u_i2c_scl_phase_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .cmd(cmd), .div_cfg(div_cfg),
    .scl_in(scl_in), .scl_pull(scl_pull), .chg_stb(chg_stb),
    .smp_stb(smp_stb), .cond_stb(cond_stb), .cmd_take(cmd_take), .busy(busy)
  );

  assign scl_in = ~scl_pull & ~stretch;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // divider word and slave stretching, driven 2 ns after each edge
  always @(posedge clk) begin
    #2;
    if (div_rand) begin
      if ($urandom % 6 == 0) div_cfg = {16'($urandom % 6), 16'($urandom % 6)};
    end else begin
      div_cfg = div_force;
    end
    stretch = stretch_en && ($urandom % 3 == 0);
  end

  // phase monitor
  bit         in_low, hs_open, hs_data, was_busy;
  int         low_idx, chg_n, take_n, hs_cnt, hs_smp, lat_lo, lat_hi;
  int         cond_seen, smp_seen;
  logic [1:0] taken;
  logic [31:0] prev_div;

  task automatic close_seg();
    chk(hs_cnt == (lat_hi + 1) * 8, "R1 R3 high-phase length", hs_cnt, (lat_hi + 1) * 8);
    chk(hs_smp == (hs_data ? 1 : 0), "R7 sample strobes per phase", hs_smp, hs_data ? 1 : 0);
    hs_open = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst_n || !run) begin
      in_low  = 1'b0;
      hs_open = 1'b0;
    end else begin
      if (scl_pull) begin
        if (!in_low) begin
          if (hs_open) close_seg();
          in_low  = 1'b1;
          low_idx = 0;
          chg_n   = 0;
          take_n  = 0;
          lat_lo  = prev_div[15:0];
          lat_hi  = prev_div[31:16];
        end
        if (chg_stb) begin
          chk(low_idx == (lat_lo + 1) * 4 - 1, "R6 change strobe position", low_idx, (lat_lo + 1) * 4 - 1);
          chg_n++;
        end
        if (cmd_take) begin
          chk(low_idx == (lat_lo + 1) * 8 - 1, "R9 take in last low cycle", low_idx, (lat_lo + 1) * 8 - 1);
          take_n++;
          taken = cmd;
        end
        low_idx++;
      end else begin
        if (in_low) begin
          chk(low_idx == (lat_lo + 1) * 8, "R1 R2 low-phase length", low_idx, (lat_lo + 1) * 8);
          chk(chg_n == 1, "R6 change strobes per low phase", chg_n, 1);
          chk(take_n == 1, "R9 takes per low phase", take_n, 1);
          in_low = 1'b0;
          if (busy) begin
            hs_open = 1'b1;
            hs_data = (taken == 2'd0) || (taken == 2'd3);
            hs_cnt  = 0;
            hs_smp  = 0;
          end
        end
        if (busy) begin
          if (!was_busy) lat_hi = prev_div[31:16];
          if (cond_stb) begin
            if (hs_open) close_seg();
            hs_open = 1'b1;
            hs_data = 1'b0;
            hs_cnt  = 0;
            hs_smp  = 0;
            cond_seen++;
          end
          if (scl_in) begin
            if (smp_stb) begin
              chk(hs_data && (hs_cnt == (lat_hi + 1) * 4 - 1), "R7 sample strobe position",
                  hs_cnt, (lat_hi + 1) * 4 - 1);
              hs_smp++;
              smp_seen++;
            end
            hs_cnt++; // R4: stretched cycles are not counted
          end
          if (cmd_take) chk(1'b0, "R9 take while clock released", 1, 0);
        end else begin
          if (hs_open) close_seg();
          if (cmd_take) chk(cmd == 2'd1, "R9 idle take only on START", cmd, 1);
        end
      end
    end
    prev_div = div_cfg;
    was_busy = busy;
  end

  task automatic wait_take();
    do @(negedge clk); while (!cmd_take);
  endtask

  // START, n slots (bit or repeated START), STOP
  task automatic do_txn(input int n, input int rs_pct);
    int rs = 0;
    int nbit = 0;
    int c0 = cond_seen;
    int s0 = smp_seen;
    @(posedge clk); #2;
    run = 1'b1;
    cmd = 2'd1;
    wait_take();
    for (int i = 0; i < n; i++) begin
      logic [1:0] c;
      if (int'($urandom % 100) < rs_pct) c = 2'd1;
      else c = ($urandom % 4 == 0) ? 2'd3 : 2'd0;
      if (c == 2'd1) rs++; else nbit++;
      @(posedge clk); #2;
      cmd = c;
      wait_take();
    end
    @(posedge clk); #2;
    cmd = 2'd2;
    wait_take();
    @(posedge clk); #2;
    cmd = 2'd0;
    do @(negedge clk); while (busy);
    chk(cond_seen - c0 == 2 + rs, "R8 condition holds per transfer", cond_seen - c0, 2 + rs);
    chk(smp_seen - s0 == nbit, "R7 sample strobes per transfer", smp_seen - s0, nbit);
    chk(!scl_pull, "R8 clock released after STOP", scl_pull, 0);
    @(posedge clk); #2;
    run = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    void'($urandom(32'h1C5E_ED01));
    rst_n = 1'b0; run = 1'b0; cmd = 2'd0;
    div_force = 32'h0002_0001; div_rand = 1'b0; stretch_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!scl_pull && !busy, "R12 reset idle and released", {scl_pull, busy}, 0);
    chk({chg_stb, smp_stb, cond_stb, cmd_take} == 4'b0, "R12 reset strobes low",
        {chg_stb, smp_stb, cond_stb, cmd_take}, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;

    // R10: non-START commands while idle
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2;
      run = 1'b1;
      cmd = (k == 0) ? 2'd0 : ((k == 1) ? 2'd2 : 2'd3);
      repeat (6) @(negedge clk);
      chk(!busy && !scl_pull, "R10 idle ignores command", {busy, scl_pull}, 0);
    end
    @(posedge clk); #2;
    run = 1'b0;

    // directed patterns
    div_force = 32'h0002_0001; do_txn(3, 0);
    div_force = 32'h0000_0000; do_txn(4, 50);
    div_force = 32'h0001_0006; stretch_en = 1'b1; do_txn(4, 30); stretch_en = 1'b0;
    div_force = 32'h0005_0000; do_txn(2, 0);

    // R5: divider changed while a transfer runs
    div_force = 32'h0003_0002;
    fork
      do_txn(3, 0);
      begin
        repeat (30) @(posedge clk);
        div_force = 32'h0000_0004;
      end
    join

    // random mix
    div_rand = 1'b1;
    for (int t = 0; t < 8; t++) begin
      stretch_en = ($urandom % 2) == 1;
      do_txn(1 + int'($urandom % 5), 30);
    end
    div_rand = 1'b0;
    stretch_en = 1'b0;

    // R11: abort in the middle of a transfer
    div_force = 32'h0004_0004;
    @(posedge clk); #2;
    run = 1'b1;
    cmd = 2'd1;
    wait_take();
    @(posedge clk); #2;
    cmd = 2'd0;
    repeat (45) @(posedge clk);
    #2 run = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!busy && !scl_pull, "R11 abort releases clock", {busy, scl_pull}, 0);
    repeat (3) @(posedge clk);
    div_force = 32'h0001_0002;
    do_txn(2, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule